// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts down from a programmable start value and asks for a system reset when software stops servicing it. The count advances only on pulses of a slow tick enable (`tick_en`), which comes from a clock that runs independently of the bus. The tick rate is first divided by a power-of-two prescaler. Software talks to the block over a plain register bus with an address, write data, a write strobe and combinational read data.

Every control action is a 16-bit magic value written to a command register:
- one value starts the timer,
- one value refreshes it,
- one value opens the configuration registers for writing,
- one value closes them again.

A write to the divider or to the start value is not used by the counter straight away. It is handed over to the counting side after a fixed number of tick pulses, which models a clock-domain transfer. A status register shows which of the two handovers are still in progress.

Once the watchdog has been started, software cannot stop it. Only the system reset returns it to its idle state.

Top module: `wdg_iwdt`

## Requirements
- R1: After reset, the divider register (0x04) reads 0 and the start-value register (0x08) reads 0xFFF. The status register (0x0C) reads 0, `reset_req` is low, the configuration registers are locked and the counter is stopped.
- R2: Writing 0x5555 to bits [15:0] of the command register (0x00) unlocks the configuration registers. Writing 0x0000 locks them again. While they are locked, writes to the divider (bits [2:0] at 0x04) and to the start value (bits [11:0] at 0x08) leave the read-back value unchanged.
- R3: Writing 0xCCCC to the command register starts the counter. The first `reset_req` pulse is raised on the clock cycle after the tick edge that completes (start value + 1) × 4·2^code tick pulses, counted from the start write.
- R4: `reset_req` is high for exactly one clock cycle. The counter then reloads itself and the next timeout follows after the same period.
- R5: Writing 0xAAAA to the command register reloads the counter from the active start value and restarts the divider phase, so the next timeout comes one full period after the refresh.
- R6: Once the counter has started, no command value stops it. A lock write or an unknown value leaves the running counter expiring on schedule.
- R7: A command value other than 0xCCCC, 0xAAAA, 0x5555 and 0x0000 has no effect. In particular, it does not unlock the configuration registers.
- R8: An accepted divider write sets status bit 0, and an accepted start-value write sets status bit 1. Each bit clears after 3 tick pulses, and only then does the new value govern counting. A refresh issued while the start-value update is still pending uses the old start value.
- R9: The window register (0x10) reads 0xFFF, and the command register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse from the slow independent time base |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| reset_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The hardest case to reach from the ports is a handover caught in flight: a new start value has been accepted, but the counting side has not yet taken it up. The bench holds `tick_en` low while it writes, so both status flags can be seen standing together and staying put without ticks. In the running phase it writes a new start value and refreshes on the very next cycle. The resulting timeout length shows whether the old value or the new one was loaded. Timeouts are checked edge by edge with a short start value, and an early pulse counts as a failure.

// File: rtl/wdg_pkg.sv
// Package: wdg_pkg
// Shared register offsets and command values for the watchdog.
// Assumes byte addressing, with the command value held in write-data bits [15:0].
package wdg_pkg;

    localparam int OFS_CMD    = 'h00;
    localparam int OFS_DIV    = 'h04;
    localparam int OFS_START  = 'h08;
    localparam int OFS_STATUS = 'h0C;
    localparam int OFS_WINDOW = 'h10;

    localparam int CMD_W = 16;

    localparam logic [CMD_W-1:0] CMD_REFRESH = 16'hAAAA;
    localparam logic [CMD_W-1:0] CMD_RUN     = 16'hCCCC;
    localparam logic [CMD_W-1:0] CMD_OPEN    = 16'h5555;
    localparam logic [CMD_W-1:0] CMD_CLOSE   = 16'h0000;

    typedef enum logic [1:0] {
        KC_NONE,
        KC_RUN,
        KC_REFRESH
    } kick_e;

endpackage

// File: rtl/wdg_cmd_ctrl.sv
// Module: wdg_cmd_ctrl
// Decodes command-register writes. It holds the unlock and running flags and
// issues one-cycle start and refresh pulses.
// Assumes at most one bus write per cycle. Unknown values are dropped.
module wdg_cmd_ctrl
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              unlocked,
    output logic              running,
    output logic              load_pulse
);

    logic             cmd_wr;
    logic [CMD_W-1:0] cmd_val;
    kick_e            kick;

    assign cmd_wr  = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign cmd_val = bus_wdata[CMD_W-1:0];

    // Classify the command as run, refresh or neither.
    always_comb begin
        kick = KC_NONE;
        if (cmd_wr) begin
            if (cmd_val == CMD_RUN) begin
                kick = KC_RUN;
            end else if (cmd_val == CMD_REFRESH) begin
                kick = KC_REFRESH;
            end
        end
    end

    // Keep the unlock flag; only the open and close values change it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (cmd_wr && cmd_val == CMD_OPEN) begin
            unlocked <= 1'b1;
        end else if (cmd_wr && cmd_val == CMD_CLOSE) begin
            unlocked <= 1'b0;
        end
    end

    // Running flag: set by the run command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (kick == KC_RUN) begin
            running <= 1'b1;
        end
    end

    // Both run and refresh reload the counter in the same cycle.
    assign load_pulse = (kick != KC_NONE);

endmodule

// File: rtl/wdg_cfg_slot.sv
// Module: wdg_cfg_slot
// Holds one configuration field: a bus-side shadow copy, an active copy used
// by the counter, and a pending flag. The pending flag clears after
// SYNC_TICKS tick pulses, at which point the active copy takes the shadow value.
// Assumes that a write during a pending transfer restarts the transfer.
module wdg_cfg_slot #(
    parameter int          W          = 12,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter int          SYNC_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         pending
);

    localparam int SC_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SYNC_TICKS - 1);

    logic [SC_W-1:0] sync_cnt;

    // Capture accepted bus writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= RST_VAL;
        end else if (wr_en) begin
            shadow <= wr_val;
        end
    end

    // Count tick pulses while a transfer is pending, then commit the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            sync_cnt <= '0;
            active   <= RST_VAL;
        end else if (wr_en) begin
            pending  <= 1'b1;
            sync_cnt <= '0;
        end else if (pending && tick_en) begin
            if (sync_cnt == SC_LAST) begin
                pending <= 1'b0;
                active  <= shadow;
            end else begin
                sync_cnt <= sync_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdg_tick_div.sv
// Module: wdg_tick_div
// Divides the tick pulses by 4*2^code, with the code capped at MAX_CODE.
// It emits one pulse per divided period and runs only while the counter runs.
// Assumes that a restart takes priority over a coincident tick.
module wdg_tick_div #(
    parameter int PRE_W    = 3,
    parameter int MAX_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             running,
    input  logic             restart,
    input  logic [PRE_W-1:0] code,
    output logic             div_tick
);

    localparam int DIV_W = MAX_CODE + 2;

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] last_phase;
    logic [PRE_W-1:0] code_sat;
    logic [DIV_W:0]   span;

    // Turn the code into the last phase value of one divided period.
    always_comb begin
        code_sat   = (int'(code) > MAX_CODE) ? PRE_W'(MAX_CODE) : code;
        span       = (DIV_W+1)'(1) << (int'(code_sat) + 2);
        last_phase = DIV_W'(span - 1'b1);
    end

    assign div_tick = running && tick_en && !restart && (phase >= last_phase);

    // Advance the phase on each tick and wrap it at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (running && tick_en) begin
            if (phase >= last_phase) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdg_down_cnt.sv
// Module: wdg_down_cnt
// The down counter. A load pulse sets it to the active start value. Each
// divided tick decrements it, and a divided tick at zero raises a one-cycle
// expiry pulse and reloads the counter.
// Assumes the divided tick is never high on two consecutive cycles.
module wdg_down_cnt #(
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                div_tick,
    input  logic [RELOAD_W-1:0] start_val,
    output logic                expire
);

    logic [RELOAD_W-1:0] count;

    // Load, decrement, or wrap with an expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '1;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                count <= start_val;
            end else if (div_tick) begin
                if (count == '0) begin
                    count  <= start_val;
                    expire <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdg_iwdt.sv
// Module: wdg_iwdt (top)
// Key-protected watchdog: command decoder, two configuration slots, a tick
// divider and a down counter, plus the register read mux.
// Assumes tick_en is a single-cycle pulse already synchronous to clk.
module wdg_iwdt
    import wdg_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int RELOAD_W   = 12,
    parameter int PRE_W      = 3,
    parameter int MAX_CODE   = 6,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);

    logic                unlocked;
    logic                running;
    logic                load_pulse;
    logic                div_tick;
    logic                div_wr;
    logic                start_wr;
    logic [PRE_W-1:0]    div_shadow;
    logic [PRE_W-1:0]    div_active;
    logic                div_pend;
    logic [RELOAD_W-1:0] start_shadow;
    logic [RELOAD_W-1:0] start_active;
    logic                start_pend;

    assign div_wr   = bus_we && unlocked && (bus_addr == ADDR_W'(OFS_DIV));
    assign start_wr = bus_we && unlocked && (bus_addr == ADDR_W'(OFS_START));

    wdg_cmd_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) cmd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .unlocked   (unlocked),
        .running    (running),
        .load_pulse (load_pulse)
    );

    wdg_cfg_slot #(
        .W          (PRE_W),
        .RST_VAL    ('0),
        .SYNC_TICKS (SYNC_TICKS)
    ) div_slot_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (div_wr),
        .wr_val  (bus_wdata[PRE_W-1:0]),
        .shadow  (div_shadow),
        .active  (div_active),
        .pending (div_pend)
    );

    wdg_cfg_slot #(
        .W          (RELOAD_W),
        .RST_VAL    ('1),
        .SYNC_TICKS (SYNC_TICKS)
    ) start_slot_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (start_wr),
        .wr_val  (bus_wdata[RELOAD_W-1:0]),
        .shadow  (start_shadow),
        .active  (start_active),
        .pending (start_pend)
    );

    wdg_tick_div #(
        .PRE_W    (PRE_W),
        .MAX_CODE (MAX_CODE)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .running  (running),
        .restart  (load_pulse),
        .code     (div_active),
        .div_tick (div_tick)
    );

    wdg_down_cnt #(
        .RELOAD_W (RELOAD_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_pulse),
        .div_tick  (div_tick),
        .start_val (start_active),
        .expire    (reset_req)
    );

    // Read mux: shadow copies, status flags and the constant window value.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFS_DIV:    bus_rdata[PRE_W-1:0]    = div_shadow;
            OFS_START:  bus_rdata[RELOAD_W-1:0] = start_shadow;
            OFS_STATUS: bus_rdata[1:0]          = {start_pend, div_pend};
            OFS_WINDOW: bus_rdata[RELOAD_W-1:0] = '1;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_iwdt_chk.sv
// Module: wdg_iwdt_chk
// Property checker attached to wdg_iwdt by a bind statement.
module wdg_iwdt_chk
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int RELOAD_W = 12,
    parameter int PRE_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_we,
    input logic                reset_req,
    input logic                running,
    input logic                unlocked,
    input logic [PRE_W-1:0]    div_shadow,
    input logic [PRE_W-1:0]    div_active,
    input logic                div_pend,
    input logic [RELOAD_W-1:0] start_shadow
);

    logic cmd_wr;
    assign cmd_wr = bus_we && (bus_addr == ADDR_W'(OFS_CMD));

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R4

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> running); // R3

    AST_START_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_W-1:0] == CMD_RUN) |=> running); // R3

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R6

    AST_LOCKED_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && bus_addr == ADDR_W'(OFS_DIV)) |=> $stable(div_shadow)); // R2

    AST_LOCKED_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && bus_addr == ADDR_W'(OFS_START)) |=> $stable(start_shadow)); // R2

    AST_BADKEY_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !unlocked && bus_wdata[CMD_W-1:0] != CMD_OPEN) |=> !unlocked); // R7

    AST_DIV_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_pend) |-> (div_active == div_shadow)); // R8

endmodule

bind wdg_iwdt wdg_iwdt_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RELOAD_W (RELOAD_W),
    .PRE_W    (PRE_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .reset_req    (reset_req),
    .running      (running),
    .unlocked     (unlocked),
    .div_shadow   (div_shadow),
    .div_active   (div_active),
    .div_pend     (div_pend),
    .start_shadow (start_shadow)
);

// File: tb/wdg_iwdt_tb_top.sv
// Bench: directed scenarios, one task each, for wdg_iwdt.
module wdg_iwdt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wdg_iwdt dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Write: driven at a negedge and sampled at the next posedge. Returns at the negedge after that edge.
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // Write in the current negedge slot and return at the negedge after the sampling edge.
    task automatic write_now(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Called at the negedge after the load edge. Expects a pulse exactly n edges later and none before.
    task automatic expect_expiry(input string req, input int n);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (reset_req) early++;
        end
        check({req, " no early pulse"}, early, 0);
        @(negedge clk);
        check({req, " pulse at period end"}, reset_req, 1);
        @(negedge clk);
        check({req, " pulse one cycle"}, reset_req, 0);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        bus_read(5'h04, d); check("R1 divider reset", d, 0);
        bus_read(5'h08, d); check("R1 start reset", d, 32'hFFF);
        bus_read(5'h0C, d); check("R1 status reset", d, 0);
        check("R1 reset_req low", reset_req, 0);
    endtask

    task automatic t_locked_and_badkey();
        logic [31:0] d;
        bus_write(5'h04, 3);
        bus_read(5'h04, d); check("R2 locked divider write ignored", d, 0);
        bus_write(5'h08, 5);
        bus_read(5'h08, d); check("R2 locked start write ignored", d, 32'hFFF);
        bus_write(5'h00, 32'h1234);
        bus_write(5'h04, 2);
        bus_read(5'h04, d); check("R7 unknown key does not unlock", d, 0);
    endtask

    task automatic t_config_transfer();
        logic [31:0] d;
        tick_en = 1'b0;
        bus_write(5'h00, 32'h5555);
        bus_write(5'h04, 1);
        bus_write(5'h08, 3);
        bus_read(5'h0C, d); check("R8 both flags pending", d, 3);
        repeat (10) @(negedge clk);
        bus_read(5'h0C, d); check("R8 flags hold without ticks", d, 3);
        tick_en = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_read(5'h0C, d); check("R8 still pending after 2 ticks", d, 3);
        @(negedge clk);
        bus_read(5'h0C, d); check("R8 flags clear after 3 ticks", d, 0);
        bus_read(5'h04, d); check("R2 divider written", d, 1);
        bus_read(5'h08, d); check("R2 start written", d, 3);
        bus_write(5'h00, 32'h0000);
        bus_write(5'h04, 5);
        bus_read(5'h04, d); check("R2 relocked write ignored", d, 1);
    endtask

    task automatic t_start_and_period();
        bus_write(5'h00, 32'hCCCC);
        expect_expiry("R3 first timeout 32", 32);
        expect_expiry("R4 repeat timeout", 31);
    endtask

    task automatic t_refresh();
        repeat (7) @(negedge clk);
        write_now(5'h00, 32'hAAAA);
        expect_expiry("R5 refresh restarts period", 32);
    endtask

    task automatic t_no_stop();
        @(negedge clk);
        write_now(5'h00, 32'h0000);
        write_now(5'h00, 32'hFFFF);
        write_now(5'h00, 32'hAAAA);
        expect_expiry("R6 still running after lock/unknown", 32);
    endtask

    task automatic t_update_while_running();
        logic [31:0] d;
        @(negedge clk);
        write_now(5'h00, 32'h5555);
        write_now(5'h08, 1);
        bus_read(5'h0C, d); check("R8 start flag set", d, 2);
        write_now(5'h00, 32'hAAAA);
        expect_expiry("R8 refresh during pending uses old value", 32);
        bus_read(5'h0C, d); check("R8 start flag cleared", d, 0);
        write_now(5'h00, 32'hAAAA);
        expect_expiry("R8 new start value 16", 16);
        write_now(5'h08, 7);
        write_now(5'h04, 0);
        repeat (4) @(negedge clk);
        bus_read(5'h0C, d); check("R8 both flags cleared", d, 0);
        write_now(5'h00, 32'hAAAA);
        expect_expiry("R3 divider code 0 period 32", 32);
    endtask

    task automatic t_fixed_regs();
        logic [31:0] d;
        bus_read(5'h10, d); check("R9 window reads FFF", d, 32'hFFF);
        bus_read(5'h00, d); check("R9 command reads 0", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_locked_and_badkey();
        t_config_transfer();
        t_start_and_period();
        t_refresh();
        t_no_stop();
        t_update_while_running();
        t_fixed_regs();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule